// File: doc/BRIEF.md
# Reference clock loss supervisor

This block watches a slow reference clock from a fast, free-running system clock. It decides when a downstream clock-synthesis loop must be treated as unlocked, and it gates that loop's output. The reference passes through a synchronizer. Rising edges are found, and the interval between successive edges is measured in system-clock cycles. An edge that comes outside a programmable tolerance of the previous interval counts as a frequency change, which also covers a glitch. An edge that is overdue by more than that tolerance starts a missing-reference episode.

A missing-reference episode ends in one of three ways:
- Skip: edges return within a short programmable skip window while skip mode is enabled and the reference is slow. Lock is kept and no relock phase follows.
- Relock: edges return later than that, or skip mode does not apply. A relock phase follows.
- Timeout: edges stay away until a longer programmable timeout, counted from the last edge. Unlock then asserts.

A frequency change while locked skips both tiers and unlocks at once. During unlock, a control bit chooses whether the synthesized output is held off or keeps running with the unlock flag marking it invalid.

Software programs the skip window, the timeout, the relock duration and the period tolerance as system-clock counts. The slow-reference threshold, which is the reference frequency below which skip mode applies, is a parameter expressed as a minimum period in system clocks.

Top module: `refclk_supervisor`

## Requirements
- R1: While reset is low, and after it is released, `unlock` is 1. It clears only after two reference edges have been measured and the reference has then stayed stable for `relockTime` cycles.
- R2: A reference whose edge-to-edge interval differs from the previous one by no more than `periodTol` cycles keeps `unlock` at 0 once locked.
- R3: With `skipEn`=1, a measured period of at least `SLOW_PERIOD` cycles, and an edge-to-edge gap of no more than `skipWindow` cycles, a missing-reference episode never asserts `unlock`.
- R4: When the measured period is below `SLOW_PERIOD`, `skipEn` has no effect: a returning edge after a short gap still asserts `unlock`.
- R5: With `skipEn`=0, during a gap shorter than `skipWindow`, `unlock` stays 0. It asserts once the edge returns and clears again after the relock time.
- R6: A gap longer than `skipWindow` but shorter than `lossTimeout` keeps `unlock` at 0 until the edge returns. `unlock` then asserts whatever `skipEn` is.
- R7: With no edge for `lossTimeout` cycles after the last edge, `unlock` asserts. Before that count it stays 0.
- R8: While locked, an edge whose interval differs from the previous one by more than `periodTol` asserts `unlock` on the next cycle, without waiting for any timeout.
- R9: `outEnable` is 1 while `unlock` is 0. While `unlock` is 1, `outEnable` equals `runWhenUnlocked`: 0 holds the output off, 1 lets it run.
- R10: After the reference returns from a timeout, `unlock` stays 1 until the relock counter has reached `relockTime`. Only then does it fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Asynchronous reference clock |
| skipEn | input | 1 | Enables tolerance of short missing-edge bursts |
| runWhenUnlocked | input | 1 | 1 keeps output running while unlocked, 0 holds it off |
| skipWindow | input | CNT_W | Longest edge-to-edge gap that skip mode tolerates, in cycles |
| lossTimeout | input | CNT_W | Cycles since the last edge before unlock on loss |
| relockTime | input | CNT_W | Stable cycles required before lock is declared |
| periodTol | input | CNT_W | Allowed interval deviation, in cycles |
| unlock | output | 1 | Loop counts as unlocked |
| outEnable | output | 1 | Enable for the synthesized output |

## Verification
The assertions assume the following about the programmed counts:
- The reference period sits well inside the tolerance band.
- `periodTol` is smaller than the period.
- The counts are ordered: period below `skipWindow`, `skipWindow` below `lossTimeout`.

The bench holds the counts fixed in that order. Its gaps are whole multiples of the reference period, placed well clear of each boundary, so that synchronizer latency of a few cycles cannot move a case across a threshold. Its random draws choose only gap length, skip enable and the output bit from those safe classes.

// File: rtl/refsup_pkg.sv
package refsup_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED   = 2'd0,
    ST_MISSING  = 2'd1,
    ST_UNLOCKED = 2'd2,
    ST_RELOCK   = 2'd3
  } supState_e;

  // datapath -> control
  typedef struct packed {
    logic edgeSeen;
    logic perChange;
    logic overdue;
    logic slowRef;
    logic withinSkip;
    logic timedOut;
    logic stable;
    logic relockDone;
  } refStatus_t;

  // control -> datapath
  typedef struct packed {
    logic holdPeriod;
    logic relockClr;
    logic relockRun;
  } refCtrl_t;

endpackage

// File: rtl/refsup_datapath.sv
module refsup_datapath
  import refsup_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_PERIOD = 1563
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic [CNT_W-1:0] skipWindow,
  input  logic [CNT_W-1:0] lossTimeout,
  input  logic [CNT_W-1:0] relockTime,
  input  logic [CNT_W-1:0] periodTol,
  input  refCtrl_t         ctrl,
  output refStatus_t       stat
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_PERIOD);

  // synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= refIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic syncLvl;
  logic prevLvl;
  logic edgeNow;

  assign syncLvl = syncQ[SYNC_STAGES-1];
  assign edgeNow = syncLvl & ~prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncLvl;
  end

  // interval measurement
  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] prevPeriod;
  logic [1:0]       edgesSeen;
  logic             havePeriod;

  assign havePeriod = (edgesSeen == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (edgeNow) begin
      gapCnt <= '0;
    end else if (gapCnt != CNT_MAX) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPeriod <= '0;
      edgesSeen  <= 2'd0;
    end else if (edgeNow) begin
      if (!ctrl.holdPeriod) prevPeriod <= gapCnt;
      if (edgesSeen != 2'd2) edgesSeen <= edgesSeen + 2'd1;
    end
  end

  logic [CNT_W:0] absDiff;
  logic [CNT_W:0] lateLimit;
  logic           perChange;
  logic           overdue;

  always_comb begin
    if (gapCnt >= prevPeriod) absDiff = {1'b0, gapCnt} - {1'b0, prevPeriod};
    else                      absDiff = {1'b0, prevPeriod} - {1'b0, gapCnt};
    lateLimit = {1'b0, prevPeriod} + {1'b0, periodTol};
  end

  assign perChange = edgeNow & havePeriod & (absDiff > {1'b0, periodTol});
  assign overdue   = havePeriod & ({1'b0, gapCnt} > lateLimit);

  // relock qualification counter
  logic [CNT_W-1:0] relockCnt;
  logic             stableNow;
  logic             relockDone;

  assign stableNow  = havePeriod & ~overdue & ~perChange;
  assign relockDone = (relockCnt >= relockTime);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relockCnt <= '0;
    end else if (ctrl.relockClr || !stableNow) begin
      relockCnt <= '0;
    end else if (ctrl.relockRun && !relockDone) begin
      relockCnt <= relockCnt + 1'b1;
    end
  end

  always_comb begin
    stat.edgeSeen   = edgeNow;
    stat.perChange  = perChange;
    stat.overdue    = overdue;
    stat.slowRef    = havePeriod & (prevPeriod >= SLOW_LIM);
    stat.withinSkip = (gapCnt <= skipWindow);
    stat.timedOut   = (gapCnt >= lossTimeout);
    stat.stable     = stableNow;
    stat.relockDone = relockDone;
  end

endmodule

// File: rtl/refsup_control.sv
module refsup_control
  import refsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       skipEn,
  input  logic       runWhenUnlocked,
  input  refStatus_t stat,
  output refCtrl_t   ctrl,
  output supState_e  curState,
  output logic       unlock,
  output logic       outEnable
);

  supState_e nextState;
  logic      skipOk;
  logic      unlockQ;

  assign skipOk = skipEn & stat.slowRef & stat.withinSkip;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_LOCKED: begin
        if (stat.perChange)    nextState = ST_UNLOCKED;
        else if (stat.overdue) nextState = ST_MISSING;
      end
      ST_MISSING: begin
        if (stat.edgeSeen)      nextState = skipOk ? ST_LOCKED : ST_RELOCK;
        else if (stat.timedOut) nextState = ST_UNLOCKED;
      end
      ST_UNLOCKED: begin
        if (stat.edgeSeen) nextState = ST_RELOCK;
      end
      ST_RELOCK: begin
        if (stat.relockDone && stat.stable) nextState = ST_LOCKED;
      end
      default: nextState = ST_RELOCK;
    endcase
  end

  always_comb begin
    ctrl.holdPeriod = (curState == ST_MISSING) & stat.edgeSeen & skipOk;
    ctrl.relockClr  = (curState != ST_RELOCK);
    ctrl.relockRun  = (curState == ST_RELOCK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_RELOCK;
      unlockQ  <= 1'b1;
    end else begin
      curState <= nextState;
      unlockQ  <= (nextState == ST_UNLOCKED) || (nextState == ST_RELOCK);
    end
  end

  assign unlock    = unlockQ;
  assign outEnable = ~unlockQ | runWhenUnlocked;

endmodule

// File: rtl/refclk_supervisor.sv
module refclk_supervisor
  import refsup_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_PERIOD = 1563
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             skipEn,
  input  logic             runWhenUnlocked,
  input  logic [CNT_W-1:0] skipWindow,
  input  logic [CNT_W-1:0] lossTimeout,
  input  logic [CNT_W-1:0] relockTime,
  input  logic [CNT_W-1:0] periodTol,
  output logic             unlock,
  output logic             outEnable
);

  refStatus_t stat;
  refCtrl_t   ctrl;
  supState_e  curState;

  refsup_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .SLOW_PERIOD(SLOW_PERIOD)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .refIn      (refIn),
    .skipWindow (skipWindow),
    .lossTimeout(lossTimeout),
    .relockTime (relockTime),
    .periodTol  (periodTol),
    .ctrl       (ctrl),
    .stat       (stat)
  );

  refsup_control ctl (
    .clk            (clk),
    .rstN           (rstN),
    .skipEn         (skipEn),
    .runWhenUnlocked(runWhenUnlocked),
    .stat           (stat),
    .ctrl           (ctrl),
    .curState       (curState),
    .unlock         (unlock),
    .outEnable      (outEnable)
  );

endmodule

// File: rtl/refsup_checker.sv
module refsup_checker
  import refsup_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       skipEn,
  input logic       unlock,
  input logic       outEnable,
  input refStatus_t stat,
  input supState_e  curState
);

  assert_reset_unlock_R1: assert property (@(posedge clk)
    !rstN |=> unlock);

  assert_locked_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_LOCKED || curState == ST_MISSING) |-> (!unlock && outEnable));

  assert_skip_keeps_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_MISSING && stat.edgeSeen && skipEn && stat.slowRef && stat.withinSkip)
      |=> !unlock);

  assert_fast_ignores_skip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_MISSING && stat.edgeSeen && !stat.slowRef) |=> unlock);

  assert_timeout_unlocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_MISSING && !stat.edgeSeen && stat.timedOut) |=> unlock);

  assert_change_unlocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_LOCKED && stat.perChange) |=> unlock);

  assert_relock_counted_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlock) |-> $past(stat.relockDone));

endmodule

bind refclk_supervisor refsup_checker chk (
  .clk      (clk),
  .rstN     (rstN),
  .skipEn   (skipEn),
  .unlock   (unlock),
  .outEnable(outEnable),
  .stat     (stat),
  .curState (curState)
);

// File: tb/refclk_supervisor_test.sv
module refclk_supervisor_test;

  localparam int CW    = 16;
  localparam int SLOW  = 30;
  localparam int SKIPW = 150;
  localparam int TOUT  = 400;
  localparam int RELK  = 100;
  localparam int TOL   = 3;
  localparam int PSLOW = 40;
  localparam int PFAST = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic skipEn = 1'b0;
  logic runWhenUnlocked = 1'b0;
  logic unlock, outEnable;

  int checks = 0;
  int fails  = 0;
  bit sawUnlock = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  refclk_supervisor #(.CNT_W(CW), .SYNC_STAGES(2), .SLOW_PERIOD(SLOW)) uut (
    .clk            (clk),
    .rstN           (rstN),
    .refIn          (refIn),
    .skipEn         (skipEn),
    .runWhenUnlocked(runWhenUnlocked),
    .skipWindow     (CW'(SKIPW)),
    .lossTimeout    (CW'(TOUT)),
    .relockTime     (CW'(RELK)),
    .periodTol      (CW'(TOL)),
    .unlock         (unlock),
    .outEnable      (outEnable)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulses(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      refIn = 1'b1;
      tick(per / 2);
      refIn = 1'b0;
      tick(per - per / 2);
    end
  endtask

  // expected outcome of a missing-edge episode from the requirements
  function automatic bit expectSurvive(input bit skip, input int per, input int gapTotal);
    return skip && (per >= SLOW) && (gapTotal <= SKIPW);
  endfunction

  function automatic bit expectOe(input bit unl, input bit run);
    return unl ? run : 1'b1;
  endfunction

  // R9 output gating monitor, plus unlock observer
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (unlock) sawUnlock = 1'b1;
      checks++;
      if (outEnable !== expectOe(unlock, runWhenUnlocked)) begin
        fails++;
        $display("FAIL R9 actual=%0d expected=%0d", outEnable, expectOe(unlock, runWhenUnlocked));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    tick(5);
    chk(unlock == 1'b1, "R1 unlock in reset", unlock, 1);
    chk(outEnable == 1'b0, "R9 held off in reset", outEnable, 0);
    rstN = 1'b1;

    // R1: not yet qualified after 3 edges
    pulses(PSLOW, 3);
    chk(unlock == 1'b1, "R1 still relocking", unlock, 1);
    pulses(PSLOW, 10);
    chk(unlock == 1'b0, "R1 lock acquired", unlock, 0);
    chk(outEnable == 1'b1, "R9 running when locked", outEnable, 1);

    // R2: small deviation inside tolerance
    sawUnlock = 1'b0;
    pulses(PSLOW + 2, 10);
    pulses(PSLOW, 5);
    chk(sawUnlock == 1'b0, "R2 jitter in tolerance", sawUnlock, 0);

    // R3: skip mode bridges a short gap
    skipEn = 1'b1;
    sawUnlock = 1'b0;
    tick(80);
    pulses(PSLOW, 10);
    chk(sawUnlock == !expectSurvive(1'b1, PSLOW, PSLOW + 80), "R3 skip keeps lock",
        sawUnlock, !expectSurvive(1'b1, PSLOW, PSLOW + 80));

    // R5: same gap, skip disabled
    skipEn = 1'b0;
    sawUnlock = 1'b0;
    tick(80);
    chk(sawUnlock == 1'b0, "R5 output continues during gap", sawUnlock, 0);
    refIn = 1'b1;
    tick(20);
    chk(unlock == 1'b1, "R5 unlock after return", unlock, 1);
    refIn = 1'b0;
    tick(20);
    pulses(PSLOW, 8);
    chk(unlock == 1'b0, "R5 relocked", unlock, 0);

    // R4: fast reference ignores skip enable
    pulses(PFAST, 15);
    chk(unlock == 1'b0, "R4 locked on fast ref", unlock, 0);
    skipEn = 1'b1;
    tick(40);
    refIn = 1'b1;
    tick(10);
    chk(unlock == 1'b1, "R4 skip ignored on fast ref", unlock, 1);
    refIn = 1'b0;
    tick(10);
    pulses(PFAST, 15);
    pulses(PSLOW, 15);
    chk(unlock == 1'b0, "R4 relocked slow", unlock, 0);

    // R6: gap beyond skip window, before timeout
    sawUnlock = 1'b0;
    tick(160);
    chk(sawUnlock == 1'b0, "R6 output continues until return", sawUnlock, 0);
    refIn = 1'b1;
    tick(10);
    chk(unlock == 1'b1, "R6 relock despite skip enable", unlock, 1);
    refIn = 1'b0;
    tick(30);
    pulses(PSLOW, 10);
    chk(unlock == 1'b0, "R6 relocked", unlock, 0);

    // R7/R10: timeout, output held then running
    for (int pass = 0; pass < 2; pass++) begin
      runWhenUnlocked = pass[0];
      tick(335);
      chk(unlock == 1'b0, "R7 no unlock before timeout", unlock, 0);
      tick(45);
      chk(unlock == 1'b1, "R7 unlock at timeout", unlock, 1);
      chk(outEnable == runWhenUnlocked, "R9 output while unlocked", outEnable, runWhenUnlocked);
      tick(200);
      pulses(PSLOW, 2);
      chk(unlock == 1'b1, "R10 held for relock time", unlock, 1);
      pulses(PSLOW, 8);
      chk(unlock == 1'b0, "R10 lock resumes", unlock, 0);
    end
    runWhenUnlocked = 1'b0;

    // R8: abrupt period change
    pulses(26, 1);
    refIn = 1'b1;
    tick(6);
    chk(unlock == 1'b1, "R8 immediate unlock on period change", unlock, 1);
    tick(14);
    refIn = 1'b0;
    tick(20);
    pulses(PSLOW, 10);
    chk(unlock == 1'b0, "R8 relocked", unlock, 0);

    // R8: glitch pulse
    refIn = 1'b1;
    tick(20);
    refIn = 1'b0;
    tick(5);
    refIn = 1'b1;
    tick(2);
    refIn = 1'b0;
    tick(5);
    chk(unlock == 1'b1, "R8 glitch unlocks", unlock, 1);
    tick(8);
    pulses(PSLOW, 10);
    chk(unlock == 1'b0, "R8 relocked after glitch", unlock, 0);

    // random episodes
    for (int it = 0; it < 30; it++) begin
      bit skip;
      int extra;
      bit surv;
      skip = 1'($urandom % 2);
      extra = PSLOW * (2 + 2 * int'($urandom % 3));
      surv = expectSurvive(skip, PSLOW, PSLOW + extra);
      skipEn = skip;
      runWhenUnlocked = 1'($urandom % 2);
      sawUnlock = 1'b0;
      tick(extra);
      pulses(PSLOW, 1);
      if (surv) chk(sawUnlock == 1'b0, "R3 random skip", sawUnlock, 0);
      else      chk(sawUnlock == 1'b1, "R6 random relock", sawUnlock, 1);
      pulses(PSLOW, 9);
      chk(unlock == 1'b0, "R2 random relocked", unlock, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule